// File: doc/BRIEF.md
# Keyed Sort Inverse-Permutation Unit

This unit takes a vector of lane keys and sends each lane's payload to the output lane that its key names. It is the store-like counterpart of a shuffle, an anti-shuffle. With the lane index as the payload, the output is the inverse of the key permutation. With a data lane as the payload, the output is the data scattered to the key positions, with no separate permute afterwards.

Each lane becomes a packet. The key is the routing address and the payload rides along with it. A binary radix sort on the address field delivers the packets to their places. It runs one stable partition per address bit, least significant bit first, one bit per clock, so `log2(LANES)` sorting cycles follow an accepted start.

Equal keys do not collide destructively. Because every pass is stable, tied packets come out in their original lane order. A flag reports that the key vector was not a permutation.

The controller is a three-state machine:

| State | Role |
|-------|------|
| `ST_IDLE` | Waits for work. Results stay held. |
| `ST_SORT` | Performs one radix pass per cycle. |
| `ST_DONE` | Presents the finished result for one cycle. |

Its transitions are:

- `ST_IDLE` goes to `ST_SORT` when `start` is high. This loads the packets and the duplicate flag.
- `ST_SORT` stays in `ST_SORT` while the current pass is not the last.
- `ST_SORT` goes to `ST_DONE` after the pass on the top address bit.
- `ST_DONE` returns to `ST_IDLE` unconditionally.

`LANES` must be a power of two, at least 2. `DATA_W` must be at least `log2(LANES)`.

Top module: `perm_invert_sorter`

## Requirements
- R1: After reset, `busy`, `done` and `dup_err` are 0 and every lane of `result_flat` is 0.
- R2: The accepting edge is a rising edge with `start` high while idle. From that edge, `busy` is high for `log2(LANES)+1` cycles. `done` is high only in the last of those cycles, for exactly one cycle.
- R3: Lane i of `keys_flat` is bits `[i*log2(LANES) +: log2(LANES)]`. Lane i of `data_flat` and of `result_flat` is bits `[i*DATA_W +: DATA_W]`. With `use_data`=0 and keys forming a permutation, result lane `keys[i]` holds the value i, zero-extended.
- R4: With `use_data`=1 and keys forming a permutation, result lane `keys[i]` holds data lane i.
- R5: If keys repeat, result lane j holds the j-th payload in ascending key order. Ties keep ascending lane order.
- R6: `dup_err` is 1 from the accepting edge if any key value appears in more than one lane, and 0 otherwise.
- R7: `start` while busy, including in the done cycle, is ignored. The operation in flight ends on schedule with its original inputs, and no extra operation follows.
- R8: Changes to `keys_flat`, `data_flat` or `use_data` after the accepting edge do not affect the result. `result_flat` and `dup_err` hold from `done` until the next accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sort when idle |
| use_data | input | 1 | Payload select: 1 = data lane, 0 = lane index |
| keys_flat | input | LANES*log2(LANES) | Packed lane keys (routing addresses) |
| data_flat | input | LANES*DATA_W | Packed data lanes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dup_err | output | 1 | Keys were not a permutation |
| result_flat | output | LANES*DATA_W | Routed payloads |

## Verification
The bench builds two copies of the unit, one with LANES=8 (three radix passes) and one with LANES=16 (four passes). Both use DATA_W=8. The behavioural model therefore covers both an odd and an even number of address bits, and a stage counter that does and does not wrap. Random permutations in both payload modes check C[E[i]] = i. Crafted key vectors with ties exercise the stable ordering and the duplicate flag. Held `start` and input scrambling during a sort cover the ignore and hold rules.

// File: rtl/pis_pkg.sv
package pis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_DONE = 2'd2
    } pis_state_e;
endpackage

// File: rtl/pis_packet_former.sv
// Builds one routing packet per lane: address = key, payload = data or lane index.
module pis_packet_former #(
    parameter int LANES  = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic [LANES*IDX_W-1:0]            keys_flat,
    input  logic [LANES*DATA_W-1:0]           data_flat,
    input  logic                              use_data,
    output logic [LANES-1:0][IDX_W-1:0]       addr,
    output logic [LANES-1:0][DATA_W-1:0]      pay
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign addr[g] = keys_flat[g*IDX_W +: IDX_W];
        assign pay[g]  = use_data ? data_flat[g*DATA_W +: DATA_W] : DATA_W'(g);
    end
endmodule

// File: rtl/pis_dup_detect.sv
// Flags any address value that occurs in more than one lane.
module pis_dup_detect #(
    parameter int LANES = 8,
    parameter int IDX_W = 3
) (
    input  logic [LANES-1:0][IDX_W-1:0] addr,
    output logic                        dup
);
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = i + 1; j < LANES; j++) begin
                if (addr[i] == addr[j]) begin
                    dup = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pis_radix_stage.sv
// One stable partition of the packets on a selected address bit:
// packets with the bit clear move to the front, those with it set follow,
// each group keeping its incoming lane order.
module pis_radix_stage #(
    parameter int LANES  = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic [LANES-1:0][IDX_W-1:0]  addr_in,
    input  logic [LANES-1:0][DATA_W-1:0] pay_in,
    input  logic [SEL_W-1:0]             sel_bit,
    output logic [LANES-1:0][IDX_W-1:0]  addr_out,
    output logic [LANES-1:0][DATA_W-1:0] pay_out
);
    localparam int CW = IDX_W + 1;

    always_comb begin
        logic [CW-1:0] n_zero;
        logic [CW-1:0] zero_seen;
        logic [CW-1:0] one_seen;
        logic [CW-1:0] dst;
        addr_out  = '0;
        pay_out   = '0;
        n_zero    = '0;
        zero_seen = '0;
        one_seen  = '0;
        dst       = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!addr_in[i][sel_bit]) begin
                n_zero = n_zero + CW'(1);
            end
        end
        for (int i = 0; i < LANES; i++) begin
            if (addr_in[i][sel_bit]) begin
                dst      = n_zero + one_seen;
                one_seen = one_seen + CW'(1);
            end else begin
                dst       = zero_seen;
                zero_seen = zero_seen + CW'(1);
            end
            addr_out[dst[IDX_W-1:0]] = addr_in[i];
            pay_out[dst[IDX_W-1:0]]  = pay_in[i];
        end
    end
endmodule

// File: rtl/perm_invert_sorter.sv
// Keyed-sort anti-shuffle: sequential LSB-first radix sort, one address bit per cycle.
module perm_invert_sorter
    import pis_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int SEL_W = (IDX_W > 1) ? $clog2(IDX_W) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     use_data,
    input  logic [LANES*IDX_W-1:0]   keys_flat,
    input  logic [LANES*DATA_W-1:0]  data_flat,
    output logic                     busy,
    output logic                     done,
    output logic                     dup_err,
    output logic [LANES*DATA_W-1:0]  result_flat
);
    pis_state_e state_q, state_d;

    logic [SEL_W-1:0]             stage_q;
    logic [LANES-1:0][IDX_W-1:0]  addr_q;
    logic [LANES-1:0][DATA_W-1:0] pay_q;
    logic                         dup_q;

    logic [LANES-1:0][IDX_W-1:0]  form_addr;
    logic [LANES-1:0][DATA_W-1:0] form_pay;
    logic                         form_dup;
    logic [LANES-1:0][IDX_W-1:0]  pass_addr;
    logic [LANES-1:0][DATA_W-1:0] pass_pay;
    logic                         last_pass;

    pis_packet_former #(.LANES(LANES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_former (
        .keys_flat (keys_flat),
        .data_flat (data_flat),
        .use_data  (use_data),
        .addr      (form_addr),
        .pay       (form_pay)
    );

    pis_dup_detect #(.LANES(LANES), .IDX_W(IDX_W)) u_dup (
        .addr (form_addr),
        .dup  (form_dup)
    );

    pis_radix_stage #(.LANES(LANES), .IDX_W(IDX_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_pass (
        .addr_in  (addr_q),
        .pay_in   (pay_q),
        .sel_bit  (stage_q),
        .addr_out (pass_addr),
        .pay_out  (pass_pay)
    );

    assign last_pass = (stage_q == SEL_W'(IDX_W - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_SORT;
            ST_SORT: if (last_pass) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Packet datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            addr_q  <= '0;
            pay_q   <= '0;
            dup_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= form_addr;
                        pay_q   <= form_pay;
                        dup_q   <= form_dup;
                        stage_q <= '0;
                    end
                end
                ST_SORT: begin
                    addr_q  <= pass_addr;
                    pay_q   <= pass_pay;
                    stage_q <= stage_q + SEL_W'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SORT: busy = 1'b1;
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign dup_err = dup_q;

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign result_flat[g*DATA_W +: DATA_W] = pay_q[g];
    end
endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
    parameter int RES_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             dup_err,
    input logic [RES_W-1:0] result_flat
);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    assert_busy_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result_flat) && $stable(dup_err)));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(result_flat) && $stable(dup_err)));
endmodule

bind perm_invert_sorter pis_checker #(.RES_W(LANES*DATA_W)) u_pis_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .dup_err     (dup_err),
    .result_flat (result_flat)
);

// File: tb/test_perm_invert_sorter.sv
`timescale 1ns/1ps

module pis_harness #(
    parameter int LANES  = 8,
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_checks,
    output int   n_errors,
    output logic finished
);
    localparam int IDX_W = $clog2(LANES);
    localparam int NPASS = IDX_W;

    logic                    start, use_data;
    logic [LANES*IDX_W-1:0]  keys_flat;
    logic [LANES*DATA_W-1:0] data_flat;
    logic                    busy, done, dup_err;
    logic [LANES*DATA_W-1:0] result_flat;

    perm_invert_sorter #(.LANES(LANES), .DATA_W(DATA_W)) i_perm_invert_sorter (
        .clk (clk), .rst_n (rst_n), .start (start), .use_data (use_data),
        .keys_flat (keys_flat), .data_flat (data_flat),
        .busy (busy), .done (done), .dup_err (dup_err), .result_flat (result_flat)
    );

    // Behavioural reference state
    int                mcnt;
    logic              have_exp;
    logic              exp_dup;
    logic [DATA_W-1:0] exp_res [LANES];
    string             exp_tag;
    logic              run_checks;

    initial begin
        n_checks = 0;
        n_errors = 0;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s N=%0d %s: actual %0h expected %0h", tag, LANES, what, act, expv);
        end
    endtask

    // Stable sort by key, written with plain loops over key values
    task automatic build_expect();
        int j;
        int cnt [LANES];
        logic [IDX_W-1:0] k;
        j = 0;
        exp_dup = 1'b0;
        for (int v = 0; v < LANES; v++) cnt[v] = 0;
        for (int v = 0; v < LANES; v++) begin
            for (int i = 0; i < LANES; i++) begin
                k = keys_flat[i*IDX_W +: IDX_W];
                if (int'(k) == v) begin
                    exp_res[j] = use_data ? data_flat[i*DATA_W +: DATA_W] : DATA_W'(i);
                    j++;
                    cnt[v]++;
                end
            end
        end
        for (int v = 0; v < LANES; v++) if (cnt[v] > 1) exp_dup = 1'b1;
        exp_tag = exp_dup ? "R5" : (use_data ? "R4" : "R3");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt     = 0;
            have_exp = 1'b0;
            exp_dup  = 1'b0;
        end else if (mcnt == 0 && start) begin
            mcnt = NPASS + 1;
            build_expect();
            have_exp = 1'b1;
        end else if (mcnt > 0) begin
            mcnt--;
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_checks) begin
            check(busy == (mcnt > 0), "R2 R7", "busy", 64'(busy), 64'(mcnt > 0));
            check(done == (mcnt == 1), "R2 R7", "done", 64'(done), 64'(mcnt == 1));
            if (mcnt <= 1) begin
                for (int j = 0; j < LANES; j++) begin
                    logic [DATA_W-1:0] ev;
                    ev = have_exp ? exp_res[j] : '0;
                    check(result_flat[j*DATA_W +: DATA_W] == ev,
                          have_exp ? ((mcnt == 0) ? {exp_tag, " R8"} : exp_tag) : "R1",
                          $sformatf("result lane %0d", j),
                          64'(result_flat[j*DATA_W +: DATA_W]), 64'(ev));
                end
                check(dup_err == (have_exp && exp_dup), have_exp ? "R6" : "R1", "dup_err",
                      64'(dup_err), 64'(have_exp && exp_dup));
            end
        end
    end

    function automatic logic [LANES*DATA_W-1:0] rand_data();
        logic [LANES*DATA_W-1:0] v;
        for (int b = 0; b < LANES*DATA_W; b++) v[b] = 1'($urandom % 2);
        return v;
    endfunction

    function automatic logic [LANES*IDX_W-1:0] rand_perm();
        int p [LANES];
        logic [LANES*IDX_W-1:0] v;
        for (int i = 0; i < LANES; i++) p[i] = i;
        for (int i = LANES - 1; i > 0; i--) begin
            int j, t;
            j = int'($urandom_range(0, i));
            t = p[i]; p[i] = p[j]; p[j] = t;
        end
        for (int i = 0; i < LANES; i++) v[i*IDX_W +: IDX_W] = IDX_W'(p[i]);
        return v;
    endfunction

    task automatic run_op(input logic [LANES*IDX_W-1:0] k, input logic [LANES*DATA_W-1:0] d,
                          input bit mode, input bit hold, input bit scramble);
        @(negedge clk);
        keys_flat = k;
        data_flat = d;
        use_data  = mode;
        start     = 1'b1;
        repeat (NPASS + 2) begin
            @(negedge clk);
            if (!hold) start = 1'b0;
            if (scramble) begin
                keys_flat = rand_perm();
                data_flat = rand_data();
                use_data  = ~use_data;
            end
        end
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [LANES*IDX_W-1:0] k;
        start      = 1'b0;
        use_data   = 1'b0;
        keys_flat  = '0;
        data_flat  = '0;
        finished   = 1'b0;
        run_checks = 1'b0;
        wait (rst_n === 1'b1);
        @(negedge clk);
        run_checks = 1'b1;
        repeat (2) @(negedge clk);          // R1: idle checks after reset

        for (int i = 0; i < LANES; i++) k[i*IDX_W +: IDX_W] = IDX_W'(i);
        run_op(k, rand_data(), 1'b0, 1'b0, 1'b0);    // R3 identity
        for (int i = 0; i < LANES; i++) k[i*IDX_W +: IDX_W] = IDX_W'(LANES - 1 - i);
        run_op(k, rand_data(), 1'b1, 1'b0, 1'b0);    // R4 reversal

        for (int it = 0; it < 16; it++) begin        // R3 R4 R7 R8 random permutations
            run_op(rand_perm(), rand_data(), it[0], (it % 3) == 0, (it % 4) >= 2);
        end

        k = '0;
        run_op(k, rand_data(), 1'b1, 1'b0, 1'b0);    // R5 R6 all keys equal
        k = rand_perm();
        k[IDX_W +: IDX_W] = k[0 +: IDX_W];
        run_op(k, rand_data(), 1'b0, 1'b0, 1'b1);    // R5 R6 one repeated key
        for (int i = 0; i < LANES; i++) k[i*IDX_W +: IDX_W] = IDX_W'((i / 2) * 2);
        run_op(k, rand_data(), 1'b1, 1'b1, 1'b0);    // R5 R6 pairs of ties
        run_op(rand_perm(), rand_data(), 1'b0, 1'b0, 1'b0);  // R6 flag clears

        finished = 1'b1;
    end
endmodule

module test_perm_invert_sorter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c8, e8, c16, e16;
    logic f8, f16;
    int   timeout_err;

    always #4 clk = ~clk;   // 125 MHz

    pis_harness #(.LANES(8),  .DATA_W(8)) u_h8  (.clk(clk), .rst_n(rst_n), .n_checks(c8),  .n_errors(e8),  .finished(f8));
    pis_harness #(.LANES(16), .DATA_W(8)) u_h16 (.clk(clk), .rst_n(rst_n), .n_checks(c16), .n_errors(e16), .finished(f16));

    initial begin
        timeout_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(posedge clk);
            if (f8 === 1'b1 && f16 === 1'b1) break;
        end
        if (!(f8 === 1'b1 && f16 === 1'b1)) begin
            timeout_err = 1;
            $display("FAIL watchdog: actual not finished expected finished");
        end
        $display("Simulation finished: %0d checks, %0d errors",
                 c8 + c16 + timeout_err, e8 + e16 + timeout_err);
        $finish;
    end
endmodule